// File: doc/BRIEF.md
# Timer Tick Source Selector

This block decides when an 8-bit timer advances. It produces a count-enable strobe, `tick_o`, that lasts one system clock cycle. A 3-bit select input chooses where the strobe comes from:

- nothing, which stops the timer;
- every system clock;
- one of four taps of a free-running prescaler;
- falling or rising edges on an asynchronous external pin.

The timer core simply increments whenever `tick_o` is high.

The prescaler runs all the time from reset. Because of that, the divided taps keep a fixed phase relative to reset and do not restart when the select changes. The external pin passes through a two-flop synchronizer and a further history flop, and an edge between the last two stages gives one strobe. Transitions count whatever drives the pin, so the timer's own system can make counts by toggling it. The strobe is registered. It reflects the select value present at the clock edge that loads it.

Top module: `tick_source_sel`

## Requirements
- R1: While `rst` is high, `tick_o` is 0 whatever the select. A reset also restarts the prescaler, so the divided phase is counted again from the first clock edge after `rst` falls.
- R2: With select `3'b000`, `tick_o` is 0 on the clock edge after the select is seen.
- R3: With select `3'b001`, `tick_o` is 1 on every clock edge at which the select is seen.
- R4: Selects `3'b010`, `3'b011`, `3'b100` and `3'b101` divide by 8, 64, 256 and 1024. Number the clock edges after reset release 1, 2, 3 and so on. Edge n loads `tick_o` = 1 exactly when n is a nonzero multiple of the divisor.
- R5: With select `3'b110`, each high-to-low change on `ext_i` gives exactly one `tick_o` pulse. Each level must be held for at least 4 clocks. The change is made between edges, and the pulse is loaded on the third clock edge after it.
- R6: With select `3'b111`, each low-to-high change on `ext_i` gives exactly one `tick_o` pulse, with the same timing as R5.
- R7: In either external mode, a pin change of the other polarity produces no pulse.
- R8: A select change takes effect on the very next clock edge. For example, going from `3'b001` to `3'b000` removes the strobe at once, and no cycle ever carries more than one tick.
- R9: The pin history is tracked in every mode. Switching into an external mode while the pin rests at a level it reached long before produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 3 | Tick source select |
| ext_i | input | 1 | Asynchronous external count pin |
| tick_o | output | 1 | One-cycle count-enable strobe |

## Verification
The hardest case to reach is the alignment of the slowest tap, divide by 1024, with the reset phase after the select has moved around. The alignment must hold across a reset in mid-run while the select hops between modes. The stimulus applies random select changes over a few thousand cycles and pulses reset part way through. It then holds the slowest setting for over two full periods and checks every cycle against an edge count kept since release.

The external path is driven with randomly spaced pin toggles under both polarities, so matching and non-matching edges are mixed. A mode switch is also made while the pin has rested at a level for a long time.

// File: rtl/tick_sel_pkg.sv
package tick_sel_pkg;
  typedef enum logic [2:0] {
    SEL_STOP     = 3'b000,
    SEL_DIRECT   = 3'b001,
    SEL_DIV_A    = 3'b010,
    SEL_DIV_B    = 3'b011,
    SEL_DIV_C    = 3'b100,
    SEL_DIV_D    = 3'b101,
    SEL_EXT_FALL = 3'b110,
    SEL_EXT_RISE = 3'b111
  } tick_sel_e;

  localparam int NUM_TAPS = 4;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int TAP0_W = 3,
  parameter int TAP1_W = 6,
  parameter int TAP2_W = 8,
  parameter int TAP3_W = 10
) (
  input  logic                           clk,
  input  logic                           rst,
  output logic [tick_sel_pkg::NUM_TAPS-1:0] tap_o
);
  localparam int CNT_W = TAP3_W;
  localparam int TAP_W [tick_sel_pkg::NUM_TAPS] = '{TAP0_W, TAP1_W, TAP2_W, TAP3_W};

  logic [CNT_W-1:0] cnt_q;

  // Free-running divider; never reloaded except by reset.
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  // A tap fires when its low-order field is all ones.
  for (genvar g = 0; g < tick_sel_pkg::NUM_TAPS; g++) begin : g_tap
    assign tap_o[g] = &cnt_q[TAP_W[g]-1:0];
  end

  // R4: each divided pulse lasts a single cycle
  a_r4_tap_single: assert property (@(posedge clk) disable iff (rst)
    tap_o[0] |=> !tap_o[0]);

  // R4: a slower tap only fires together with every faster tap
  for (genvar g = 1; g < tick_sel_pkg::NUM_TAPS; g++) begin : g_nest
    a_r4_taps_nested: assert property (@(posedge clk) disable iff (rst)
      tap_o[g] |-> tap_o[g-1]);
  end
endmodule

// File: rtl/tick_ext_edge.sv
module tick_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int HIST_W = SYNC_STAGES + 1;

  logic [HIST_W-1:0] hist_q;

  // Synchronizer chain followed by one history flop.
  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= {hist_q[HIST_W-2:0], pin_i};
  end

  logic cur_lvl, old_lvl;
  assign cur_lvl = hist_q[SYNC_STAGES-1];
  assign old_lvl = hist_q[SYNC_STAGES];

  assign rise_o =  cur_lvl & ~old_lvl;
  assign fall_o = ~cur_lvl &  old_lvl;

  // R6: a rising edge is reported for one cycle only
  a_r6_rise_single: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

  // R5: a falling edge is reported for one cycle only
  a_r5_fall_single: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tick_source_sel.sv
module tick_source_sel #(
  parameter int TAP0_W      = 3,
  parameter int TAP1_W      = 6,
  parameter int TAP2_W      = 8,
  parameter int TAP3_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel_i,
  input  logic       ext_i,
  output logic       tick_o
);
  import tick_sel_pkg::*;

  logic [NUM_TAPS-1:0] tap;
  logic                ext_rise, ext_fall;
  logic                tick_d;
  tick_sel_e           sel;

  tick_prescaler #(
    .TAP0_W(TAP0_W), .TAP1_W(TAP1_W), .TAP2_W(TAP2_W), .TAP3_W(TAP3_W)
  ) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tap_o(tap)
  );

  tick_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk   (clk),
    .rst   (rst),
    .pin_i (ext_i),
    .rise_o(ext_rise),
    .fall_o(ext_fall)
  );

  assign sel = tick_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      SEL_STOP:     tick_d = 1'b0;
      SEL_DIRECT:   tick_d = 1'b1;
      SEL_DIV_A:    tick_d = tap[0];
      SEL_DIV_B:    tick_d = tap[1];
      SEL_DIV_C:    tick_d = tap[2];
      SEL_DIV_D:    tick_d = tap[3];
      SEL_EXT_FALL: tick_d = ext_fall;
      SEL_EXT_RISE: tick_d = ext_rise;
      default:      tick_d = 1'b0;
    endcase
  end

  // Registered strobe so the timer sees a clean, glitch-free enable.
  always_ff @(posedge clk) begin
    if (rst) tick_o <= 1'b0;
    else     tick_o <= tick_d;
  end

  // R2: stopped setting yields no strobe
  a_r2_stop_quiet: assert property (@(posedge clk) disable iff (rst)
    (sel_i == 3'b000) |=> !tick_o);

  // R3: undivided setting strobes every cycle
  a_r3_direct_every: assert property (@(posedge clk) disable iff (rst)
    (sel_i == 3'b001) |=> tick_o);

  // R4: slowest divider never strobes in two adjacent cycles
  a_r4_slow_gap: assert property (@(posedge clk) disable iff (rst)
    (sel_i == 3'b101 && tick_o) |=> !tick_o);
endmodule

// File: tb/tick_source_sel_bench.sv
module tick_source_sel_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel = 3'b001;
  logic       ext = 1'b0;
  logic       tick;

  int tests = 0;
  int fails = 0;
  int ecount = 0;
  int last_chg = -1000;
  bit last_dir = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_source_sel u_tick_source_sel (
    .clk(clk), .rst(rst), .sel_i(sel), .ext_i(ext), .tick_o(tick)
  );

  // Edges since reset release, kept independently of the design.
  always @(posedge clk) begin
    if (rst) ecount <= 0;
    else     ecount <= ecount + 1;
  end

  function automatic bit exp_tick(logic [2:0] s);
    case (s)
      3'b000: return 1'b0;
      3'b001: return 1'b1;
      3'b010: return ecount > 0 && ecount % 8 == 0;
      3'b011: return ecount > 0 && ecount % 64 == 0;
      3'b100: return ecount > 0 && ecount % 256 == 0;
      3'b101: return ecount > 0 && ecount % 1024 == 0;
      3'b110: return ecount == last_chg + 3 && !last_dir;
      default: return ecount == last_chg + 3 && last_dir;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] s);
    case (s)
      3'b000: return "R2";
      3'b001: return "R3";
      3'b110: return "R5/R7";
      3'b111: return "R6/R7";
      default: return "R4";
    endcase
  endfunction

  task automatic check(bit got, bit exp, string req);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: tick_o=%0b expected %0b (edge %0d, sel %03b)",
               req, got, exp, ecount, sel);
    end
  endtask

  task automatic cyc(string req);
    @(negedge clk);
    check(tick, exp_tick(sel), req);
  endtask

  task automatic toggle_pin();
    ext = ~ext;
    last_chg = ecount;
    last_dir = ext;
  endtask

  task automatic ext_run(logic [2:0] s, int n);
    sel = s;
    for (int k = 0; k < 6; k++) cyc("R9");
    for (int i = 0; i < n; i++) begin
      toggle_pin();
      for (int h = 0; h < 4 + int'($urandom % 5); h++) cyc(req_of(s));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: held in reset with the undivided select
    repeat (3) @(negedge clk);
    check(tick, 1'b0, "R1");
    rst = 1'b0;
    for (int i = 0; i < 5; i++) cyc("R3");
    sel = 3'b000;                      // R8: strobe gone on the next edge
    cyc("R8");
    for (int i = 0; i < 9; i++) cyc("R2");
    sel = 3'b010;
    for (int i = 0; i < 40; i++) cyc("R4");
    sel = 3'b011;
    for (int i = 0; i < 200; i++) cyc("R4");

    // Random select hopping among internal sources
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 16 == 0) sel = 3'($urandom % 6);
      cyc(req_of(sel));
    end

    // R1: mid-run reset, then the phase restarts from release
    rst = 1'b1;
    sel = 3'b001;
    @(negedge clk); check(tick, 1'b0, "R1");
    @(negedge clk); check(tick, 1'b0, "R1");
    rst = 1'b0;
    sel = 3'b101;
    for (int i = 0; i < 2100; i++) cyc("R1/R4");

    // External counting, both polarities
    ext_run(3'b110, 150);
    ext_run(3'b111, 150);

    // R9: pin rests high long before entering rising mode
    sel = 3'b000;
    if (!ext) toggle_pin();
    for (int i = 0; i < 8; i++) cyc("R2");
    sel = 3'b111;
    for (int i = 0; i < 8; i++) cyc("R9");
    toggle_pin();
    for (int i = 0; i < 6; i++) cyc("R7");
    toggle_pin();
    for (int i = 0; i < 6; i++) cyc("R6");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule